// File: doc/BRIEF.md
# Rectangle Fill and Copy Blitter

This block draws into a linear framebuffer kept in a byte-addressed memory. The framebuffer is described by two inputs: the number of bytes per pixel (1 to 4) and the screen width in pixels. The line pitch is their product. A command carries an operation (solid fill or rectangle copy), a 32-bit colour, source and destination corners, and a width and height in pixels. The block then runs the whole operation byte by byte through a simple memory port. The read data comes back one cycle after the read request.

A fill writes the colour bytes only along the first row of the rectangle. Every further row is then copied from that first row. A copy picks its row order and its byte order within a row from the relative position of the source and destination. This keeps overlapping moves correct.

When an operation finishes, the block pulses a done strobe. It also queues the destination rectangle, clamped to the screen, as a damage region for the refresh logic. A refresh pulse drains the queue one rectangle per cycle. A refresh that arrives while a full-screen invalidate is pending throws the whole queue away instead.

Top module: `blit_top`

## Requirements
- R1: The byte address of pixel (x, y) is bpp*x + bpp*width*y. Rows of a rectangle are spaced one pitch apart, and each row spans bpp*w bytes.
- R2: A fill (cmd_op = 0) writes byte i of every row with byte (i mod bpp) of the colour word. Byte 0 is bits 7:0. No byte outside the rectangle changes.
- R3: A fill writes the first row from the colour and reads nothing while doing so. Each later row is produced by reading the first row byte by byte, so a fill of height h makes exactly (h-1)*bpp*w reads, all inside the first row.
- R4: A copy (cmd_op = 1) of a non-overlapping rectangle leaves the destination equal to the original source contents and leaves the source unchanged.
- R5: When the destination row lies below the source row, an overlapping copy processes rows from the last upward. The result equals a copy taken from a snapshot of the source.
- R6: An overlapping copy with the destination at or above the source row processes rows top-down. Within a row, bytes are processed right-to-left when the destination column is greater than the source column, and left-to-right otherwise. Both cases give the snapshot result.
- R7: A command with zero width or zero height makes no memory access. It pulses done in the cycle after acceptance and queues no damage region.
- R8: cmd_ready is high only while idle. A command offered while busy is ignored and has no effect on memory.
- R9: done is a single-cycle pulse, exactly one per accepted command, and cmd_ready is high in the following cycle.
- R10: Each non-empty command queues its destination rectangle. A refresh pulse emits the queued rectangles on dmg_valid in the order the commands completed.
- R11: A damage rectangle whose right edge exceeds the screen width has its x clamped to at most the width and its w reduced to width minus x. The same rule applies to y and h against the height.
- R12: A refresh with inval_pending high discards every queued rectangle and emits none.
- R13: After reset, cmd_ready is 1 and mem_req, done and dmg_valid are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_bpp | input | 3 | Bytes per pixel, 1 to 4 |
| cfg_width | input | 12 | Screen width in pixels |
| cfg_height | input | 12 | Screen height in pixels |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Blitter idle, command taken when valid |
| cmd_op | input | 1 | 0 fill, 1 copy |
| cmd_color | input | 32 | Fill colour, little-endian bytes |
| cmd_sx | input | 12 | Copy source x |
| cmd_sy | input | 12 | Copy source y |
| cmd_dx | input | 12 | Destination x |
| cmd_dy | input | 12 | Destination y |
| cmd_w | input | 12 | Width in pixels |
| cmd_h | input | 12 | Height in pixels |
| mem_req | output | 1 | Memory access this cycle |
| mem_we | output | 1 | 1 write, 0 read |
| mem_addr | output | 20 | Byte address |
| mem_wdata | output | 8 | Write byte |
| mem_rdata | input | 8 | Read byte, valid one cycle after a read |
| done | output | 1 | Operation finished |
| refresh | input | 1 | Drain the damage queue |
| inval_pending | input | 1 | With refresh: discard the queue |
| dmg_valid | output | 1 | Damage rectangle present |
| dmg_x | output | 12 | Damage x |
| dmg_y | output | 12 | Damage y |
| dmg_w | output | 12 | Damage width |
| dmg_h | output | 12 | Damage height |

## Verification
Fills run at each of the four pixel sizes. A mis-strided row or a wrong colour-byte rotation shows up in the byte image, and a read-window monitor separates true row replication from recomputing every pixel. Copies cover a disjoint move, a downward and an upward overlap, and a same-row shift to the right and to the left. Only the correct row and byte ordering reproduces the snapshot result in every one of these. Rectangles that run past the right or bottom edge, zero-size commands, commands offered while busy, and refreshes with and without a pending invalidate cover clamping, queue order and discard.

// File: rtl/blit_pkg.sv
package blit_pkg;

    parameter int CW = 12;   // coordinate and size width
    parameter int AW = 20;   // byte address width

    typedef enum logic {
        OP_FILL = 1'b0,
        OP_COPY = 1'b1
    } blit_op_e;

    typedef struct packed {
        blit_op_e        op;
        logic [31:0]     color;
        logic [CW-1:0]   sx;
        logic [CW-1:0]   sy;
        logic [CW-1:0]   dx;
        logic [CW-1:0]   dy;
        logic [CW-1:0]   w;
        logic [CW-1:0]   h;
    } blit_cmd_t;

    typedef struct packed {
        logic [CW-1:0] x;
        logic [CW-1:0] y;
        logic [CW-1:0] w;
        logic [CW-1:0] h;
    } blit_rect_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ROW0,
        ST_RD,
        ST_WR,
        ST_FIN
    } blit_st_e;

    // Byte address of pixel (x, y) for a given pixel size and pitch.
    function automatic logic [AW-1:0] pix_addr(input logic [2:0]    bpp,
                                               input logic [AW-1:0] pitch,
                                               input logic [CW-1:0] x,
                                               input logic [CW-1:0] y);
        return AW'(bpp) * AW'(x) + pitch * AW'(y);
    endfunction

    // Little-endian byte select from the colour word.
    function automatic logic [7:0] color_byte(input logic [31:0] c,
                                              input logic [1:0]  sel);
        return 8'(c >> {sel, 3'b000});
    endfunction

endpackage

// File: rtl/blit_clip_axis.sv
module blit_clip_axis
    import blit_pkg::*;
(
    input  logic [CW-1:0] pos,
    input  logic [CW-1:0] len,
    input  logic [CW-1:0] lim,
    output logic [CW-1:0] pos_o,
    output logic [CW-1:0] len_o
);
    logic [CW:0] edge_sum;

    always_comb begin
        edge_sum = {1'b0, pos} + {1'b0, len};
        pos_o    = pos;
        len_o    = len;
        if (edge_sum > {1'b0, lim}) begin
            pos_o = (pos < lim) ? pos : lim;
            len_o = lim - pos_o;
        end
    end
endmodule

// File: rtl/blit_dmgq.sv
module blit_dmgq
    import blit_pkg::*;
#(
    parameter int DEPTH = 512
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       push,
    input  blit_rect_t push_rect,
    input  logic       refresh,
    input  logic       inval,
    output logic       out_valid,
    output blit_rect_t out_rect
);
    localparam int IW = $clog2(DEPTH);

    blit_rect_t      store [DEPTH];
    logic [IW-1:0]   head, tail;
    logic [IW:0]     count;
    logic            drain;
    logic            pop, drop, full, discard;

    assign discard = refresh && inval;
    assign full    = (count == (IW+1)'(DEPTH));
    assign pop     = drain && (count != '0) && !discard;
    assign drop    = push && full && !pop;   // oldest entry lost on overflow

    always_ff @(posedge clk) begin
        if (push) store[tail] <= push_rect;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            head      <= '0;
            tail      <= '0;
            count     <= '0;
            drain     <= 1'b0;
            out_valid <= 1'b0;
            out_rect  <= '0;
        end else begin
            out_valid <= pop;
            if (pop) out_rect <= store[head];
            if (push) tail <= tail + 1'b1;
            if (discard) begin
                head  <= tail;
                count <= push ? (IW+1)'(1) : '0;
                drain <= 1'b0;
            end else begin
                head  <= head + IW'(pop) + IW'(drop);
                count <= count + (IW+1)'(push) - (IW+1)'(pop) - (IW+1)'(drop);
                if (refresh)
                    drain <= 1'b1;
                else if (drain && count == '0 && !push)
                    drain <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/blit_engine.sv
module blit_engine
    import blit_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic [2:0]    cfg_bpp,
    input  logic [CW-1:0] cfg_width,
    input  logic          cmd_valid,
    input  blit_cmd_t     cmd,
    output logic          cmd_ready,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [7:0]    mem_wdata,
    input  logic [7:0]    mem_rdata,
    output logic          done,
    output logic          dmg_push,
    output blit_rect_t    dmg_rect
);
    blit_st_e       st;
    logic           is_copy, up, rev, nz;
    logic [2:0]     bpp;
    logic [AW-1:0]  pitch, rb, src_row, dst_row, off, bcnt;
    logic [CW-1:0]  rcnt;
    logic [31:0]    color;
    logic [1:0]     csel;
    blit_rect_t     rect;

    // Set-up values computed at acceptance
    logic [AW-1:0]  pitch_c, rb_c, sbase_c, dbase_c, last_c;
    logic           up_c, rev_c, nz_c;

    always_comb begin
        pitch_c = AW'(cfg_bpp) * AW'(cfg_width);
        rb_c    = AW'(cfg_bpp) * AW'(cmd.w);
        sbase_c = pix_addr(cfg_bpp, pitch_c, cmd.sx, cmd.sy);
        dbase_c = pix_addr(cfg_bpp, pitch_c, cmd.dx, cmd.dy);
        last_c  = (AW'(cmd.h) - 1'b1) * pitch_c;
        up_c    = (cmd.op == OP_COPY) && (cmd.dy > cmd.sy);
        rev_c   = (cmd.op == OP_COPY) && (cmd.dx > cmd.sx);
        nz_c    = (cmd.w != '0) && (cmd.h != '0);
    end

    assign cmd_ready = (st == ST_IDLE);
    assign mem_req   = (st == ST_ROW0) || (st == ST_RD) || (st == ST_WR);
    assign mem_we    = (st == ST_ROW0) || (st == ST_WR);
    assign mem_addr  = ((st == ST_RD) ? src_row : dst_row) + off;
    assign mem_wdata = (st == ST_ROW0) ? color_byte(color, csel) : mem_rdata;
    assign done      = (st == ST_FIN);
    assign dmg_push  = (st == ST_FIN) && nz;
    assign dmg_rect  = rect;

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= ST_IDLE;
            is_copy <= 1'b0;
            up      <= 1'b0;
            rev     <= 1'b0;
            nz      <= 1'b0;
            bpp     <= 3'd1;
            pitch   <= '0;
            rb      <= '0;
            src_row <= '0;
            dst_row <= '0;
            off     <= '0;
            bcnt    <= '0;
            rcnt    <= '0;
            color   <= '0;
            csel    <= '0;
            rect    <= '0;
        end else begin
            unique case (st)
                ST_IDLE: if (cmd_valid) begin
                    is_copy <= (cmd.op == OP_COPY);
                    up      <= up_c;
                    rev     <= rev_c;
                    nz      <= nz_c;
                    bpp     <= cfg_bpp;
                    pitch   <= pitch_c;
                    rb      <= rb_c;
                    color   <= cmd.color;
                    csel    <= '0;
                    bcnt    <= rb_c;
                    rect    <= '{x: cmd.dx, y: cmd.dy, w: cmd.w, h: cmd.h};
                    if (!nz_c) begin
                        st <= ST_FIN;
                    end else if (cmd.op == OP_FILL) begin
                        dst_row <= dbase_c;
                        off     <= '0;
                        rcnt    <= cmd.h - 1'b1;
                        st      <= ST_ROW0;
                    end else begin
                        src_row <= up_c ? sbase_c + last_c : sbase_c;
                        dst_row <= up_c ? dbase_c + last_c : dbase_c;
                        off     <= rev_c ? rb_c - 1'b1 : '0;
                        rcnt    <= cmd.h;
                        st      <= ST_RD;
                    end
                end
                ST_ROW0: begin
                    if (bcnt == AW'(1)) begin
                        if (rcnt == '0) begin
                            st <= ST_FIN;
                        end else begin
                            src_row <= dst_row;
                            dst_row <= dst_row + pitch;
                            off     <= '0;
                            bcnt    <= rb;
                            st      <= ST_RD;
                        end
                    end else begin
                        off  <= off + 1'b1;
                        bcnt <= bcnt - 1'b1;
                        csel <= (3'(csel) == bpp - 3'd1) ? 2'd0 : csel + 2'd1;
                    end
                end
                ST_RD: st <= ST_WR;
                ST_WR: begin
                    if (bcnt == AW'(1)) begin
                        if (rcnt == CW'(1)) begin
                            st <= ST_FIN;
                        end else begin
                            rcnt <= rcnt - 1'b1;
                            bcnt <= rb;
                            off  <= rev ? rb - 1'b1 : '0;
                            if (is_copy) begin
                                src_row <= up ? src_row - pitch : src_row + pitch;
                                dst_row <= up ? dst_row - pitch : dst_row + pitch;
                            end else begin
                                dst_row <= dst_row + pitch;
                            end
                            st <= ST_RD;
                        end
                    end else begin
                        off  <= rev ? off - 1'b1 : off + 1'b1;
                        bcnt <= bcnt - 1'b1;
                        st   <= ST_RD;
                    end
                end
                ST_FIN: st <= ST_IDLE;
                default: st <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/blit_top.sv
module blit_top
    import blit_pkg::*;
#(
    parameter int DQ_DEPTH = 512
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [2:0]    cfg_bpp,
    input  logic [CW-1:0] cfg_width,
    input  logic [CW-1:0] cfg_height,
    input  logic          cmd_valid,
    output logic          cmd_ready,
    input  logic          cmd_op,
    input  logic [31:0]   cmd_color,
    input  logic [CW-1:0] cmd_sx,
    input  logic [CW-1:0] cmd_sy,
    input  logic [CW-1:0] cmd_dx,
    input  logic [CW-1:0] cmd_dy,
    input  logic [CW-1:0] cmd_w,
    input  logic [CW-1:0] cmd_h,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [7:0]    mem_wdata,
    input  logic [7:0]    mem_rdata,
    output logic          done,
    input  logic          refresh,
    input  logic          inval_pending,
    output logic          dmg_valid,
    output logic [CW-1:0] dmg_x,
    output logic [CW-1:0] dmg_y,
    output logic [CW-1:0] dmg_w,
    output logic [CW-1:0] dmg_h
);
    localparam int NAX = 2;   // x and y axes

    blit_cmd_t  cmd;
    blit_rect_t raw_rect, clip_rect, q_rect;
    logic       dmg_push;

    assign cmd = '{op: blit_op_e'(cmd_op), color: cmd_color,
                   sx: cmd_sx, sy: cmd_sy, dx: cmd_dx, dy: cmd_dy,
                   w: cmd_w, h: cmd_h};

    blit_engine u_eng (
        .clk       (clk),
        .rst       (rst),
        .cfg_bpp   (cfg_bpp),
        .cfg_width (cfg_width),
        .cmd_valid (cmd_valid),
        .cmd       (cmd),
        .cmd_ready (cmd_ready),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_rdata (mem_rdata),
        .done      (done),
        .dmg_push  (dmg_push),
        .dmg_rect  (raw_rect)
    );

    logic [CW-1:0] ax_pos [NAX];
    logic [CW-1:0] ax_len [NAX];
    logic [CW-1:0] ax_lim [NAX];
    logic [CW-1:0] cl_pos [NAX];
    logic [CW-1:0] cl_len [NAX];

    assign ax_pos[0] = raw_rect.x;
    assign ax_len[0] = raw_rect.w;
    assign ax_lim[0] = cfg_width;
    assign ax_pos[1] = raw_rect.y;
    assign ax_len[1] = raw_rect.h;
    assign ax_lim[1] = cfg_height;

    for (genvar a = 0; a < NAX; a++) begin : g_clip
        blit_clip_axis u_axis (
            .pos   (ax_pos[a]),
            .len   (ax_len[a]),
            .lim   (ax_lim[a]),
            .pos_o (cl_pos[a]),
            .len_o (cl_len[a])
        );
    end

    assign clip_rect = '{x: cl_pos[0], y: cl_pos[1], w: cl_len[0], h: cl_len[1]};

    blit_dmgq #(.DEPTH(DQ_DEPTH)) u_dmgq (
        .clk       (clk),
        .rst       (rst),
        .push      (dmg_push),
        .push_rect (clip_rect),
        .refresh   (refresh),
        .inval     (inval_pending),
        .out_valid (dmg_valid),
        .out_rect  (q_rect)
    );

    assign dmg_x = q_rect.x;
    assign dmg_y = q_rect.y;
    assign dmg_w = q_rect.w;
    assign dmg_h = q_rect.h;
endmodule

// File: rtl/blit_chk.sv
module blit_chk
    import blit_pkg::*;
(
    input logic          clk,
    input logic          rst,
    input logic          cmd_valid,
    input logic          cmd_ready,
    input logic [CW-1:0] cmd_w,
    input logic [CW-1:0] cmd_h,
    input logic          mem_req,
    input logic          done,
    input logic          refresh,
    input logic          inval_pending,
    input logic          dmg_valid,
    input logic [CW-1:0] dmg_x,
    input logic [CW-1:0] dmg_y,
    input logic [CW-1:0] dmg_w,
    input logic [CW-1:0] dmg_h,
    input logic [CW-1:0] cfg_width,
    input logic [CW-1:0] cfg_height
);
    p_idle_no_mem_r8: assert property (@(posedge clk) disable iff (rst)
        cmd_ready |-> !mem_req);

    p_busy_after_accept_r8: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_ready && cmd_w != '0 && cmd_h != '0) |=> !cmd_ready);

    p_zero_size_r7: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_ready && (cmd_w == '0 || cmd_h == '0)) |=> (done && !mem_req));

    p_done_pulse_r9: assert property (@(posedge clk) disable iff (rst)
        done |=> (!done && cmd_ready));

    p_dmg_clip_x_r11: assert property (@(posedge clk) disable iff (rst)
        dmg_valid |-> ({1'b0, dmg_x} + {1'b0, dmg_w} <= {1'b0, cfg_width}));

    p_dmg_clip_y_r11: assert property (@(posedge clk) disable iff (rst)
        dmg_valid |-> ({1'b0, dmg_y} + {1'b0, dmg_h} <= {1'b0, cfg_height}));

    p_discard_r12: assert property (@(posedge clk) disable iff (rst)
        (refresh && inval_pending) |=> !dmg_valid);
endmodule

bind blit_top blit_chk u_chk (.*);

// File: tb/tb_blit_top.sv
module tb_blit_top;
    import blit_pkg::*;

    localparam int SCR_W = 16;
    localparam int SCR_H = 8;
    localparam int MSZ   = 1024;
    localparam int NVEC  = 10;

    typedef struct packed {
        logic        op;
        logic [2:0]  bpp;
        logic [31:0] col;
        logic [11:0] sx, sy, dx, dy, w, h;
    } vec_t;

    // op, bpp, colour, sx, sy, dx, dy, w, h
    localparam vec_t VECS [NVEC] = '{
        '{1'b0, 3'd1, 32'h000000AB, 12'd0, 12'd0, 12'd2,  12'd1, 12'd3, 12'd2},
        '{1'b0, 3'd2, 32'h00001234, 12'd0, 12'd0, 12'd0,  12'd0, 12'd4, 12'd3},
        '{1'b0, 3'd3, 32'h00C0FFEE, 12'd0, 12'd0, 12'd5,  12'd2, 12'd2, 12'd2},
        '{1'b0, 3'd4, 32'hDEADBEEF, 12'd0, 12'd0, 12'd14, 12'd6, 12'd4, 12'd3},
        '{1'b1, 3'd1, 32'h0,        12'd0, 12'd0, 12'd4,  12'd4, 12'd3, 12'd2},
        '{1'b1, 3'd2, 32'h0,        12'd1, 12'd1, 12'd1,  12'd2, 12'd4, 12'd3},
        '{1'b1, 3'd1, 32'h0,        12'd2, 12'd3, 12'd2,  12'd1, 12'd5, 12'd4},
        '{1'b1, 3'd3, 32'h0,        12'd0, 12'd2, 12'd2,  12'd2, 12'd6, 12'd2},
        '{1'b1, 3'd4, 32'h0,        12'd3, 12'd0, 12'd1,  12'd0, 12'd4, 12'd2},
        '{1'b0, 3'd1, 32'h00000077, 12'd0, 12'd0, 12'd20, 12'd1, 12'd3, 12'd1}
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [2:0]    cfg_bpp = 3'd1;
    logic [CW-1:0] cfg_width = CW'(SCR_W);
    logic [CW-1:0] cfg_height = CW'(SCR_H);
    logic          cmd_valid = 1'b0;
    logic          cmd_ready;
    logic          cmd_op = 1'b0;
    logic [31:0]   cmd_color = '0;
    logic [CW-1:0] cmd_sx = '0, cmd_sy = '0, cmd_dx = '0, cmd_dy = '0;
    logic [CW-1:0] cmd_w = '0, cmd_h = '0;
    logic          mem_req, mem_we;
    logic [AW-1:0] mem_addr;
    logic [7:0]    mem_wdata;
    logic [7:0]    mem_rdata = '0;
    logic          done;
    logic          refresh = 1'b0;
    logic          inval_pending = 1'b0;
    logic          dmg_valid;
    logic [CW-1:0] dmg_x, dmg_y, dmg_w, dmg_h;

    always #5 clk = ~clk;

    blit_top dut (.*);

    // Memory model and monitors
    logic [7:0] mem_m [MSZ];
    logic [7:0] ref_m [MSZ];
    logic       ld_all = 1'b0;
    int         acc_cnt = 0, rd_cnt = 0, bad_rd = 0, done_cnt = 0;
    logic       win_on = 1'b0;
    int         win_lo = 0, win_hi = 0;

    always @(posedge clk) begin
        if (ld_all) begin
            for (int i = 0; i < MSZ; i++) mem_m[i] <= 8'(i * 7 + 3);
        end else if (mem_req) begin
            if (mem_we) mem_m[mem_addr[9:0]] <= mem_wdata;
            else        mem_rdata <= mem_m[mem_addr[9:0]];
        end
        if (mem_req) acc_cnt <= acc_cnt + 1;
        if (mem_req && !mem_we) begin
            rd_cnt <= rd_cnt + 1;
            if (win_on && (int'(mem_addr) < win_lo || int'(mem_addr) >= win_hi))
                bad_rd <= bad_rd + 1;
        end
        if (done) done_cnt <= done_cnt + 1;
    end

    int checks = 0, errors = 0;
    int got_n;
    logic [CW-1:0] got_x [4], got_y [4], got_w [4], got_h [4];

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic load_mem();
        @(negedge clk); ld_all = 1'b1;
        @(negedge clk); ld_all = 1'b0;
        for (int i = 0; i < MSZ; i++) ref_m[i] = 8'(i * 7 + 3);
    endtask

    task automatic run_cmd(input logic op, input logic [31:0] col,
                           input logic [11:0] sx, sy, dx, dy, w, h);
        int n;
        @(negedge clk);
        cmd_op = op; cmd_color = col; cmd_sx = sx; cmd_sy = sy;
        cmd_dx = dx; cmd_dy = dy; cmd_w = w; cmd_h = h; cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        n = 0;
        while (!done && n < 5000) begin @(negedge clk); n++; end
        @(negedge clk);
    endtask

    task automatic get_dmg(input logic inv);
        got_n = 0;
        @(negedge clk); refresh = 1'b1; inval_pending = inv;
        @(negedge clk); refresh = 1'b0; inval_pending = 1'b0;
        for (int k = 0; k < 10; k++) begin
            if (dmg_valid && got_n < 4) begin
                got_x[got_n] = dmg_x; got_y[got_n] = dmg_y;
                got_w[got_n] = dmg_w; got_h[got_n] = dmg_h;
                got_n++;
            end
            @(negedge clk);
        end
    endtask

    // Reference models
    task automatic ref_fill(input int bpp, input logic [31:0] col, input int x, y, w, h);
        int pitch = bpp * SCR_W;
        for (int r = 0; r < h; r++)
            for (int i = 0; i < bpp * w; i++)
                ref_m[(bpp * x + pitch * (y + r) + i) % MSZ] = 8'(col >> (8 * (i % bpp)));
    endtask

    task automatic ref_copy(input int bpp, input int sx, sy, dx, dy, w, h);
        logic [7:0] tmp [512];
        int pitch = bpp * SCR_W;
        for (int r = 0; r < h; r++)
            for (int i = 0; i < bpp * w; i++)
                tmp[r * bpp * w + i] = ref_m[bpp * sx + pitch * (sy + r) + i];
        for (int r = 0; r < h; r++)
            for (int i = 0; i < bpp * w; i++)
                ref_m[bpp * dx + pitch * (dy + r) + i] = tmp[r * bpp * w + i];
    endtask

    function automatic void clamp(input int p, l, lim, output int po, lo);
        po = p; lo = l;
        if (p + l > lim) begin
            po = (p < lim) ? p : lim;
            lo = lim - po;
        end
    endfunction

    task automatic cmp_mem(input string tag);
        int bad = 0, ba = 0;
        for (int i = 0; i < MSZ; i++)
            if (mem_m[i] !== ref_m[i]) begin
                if (bad == 0) ba = i;
                bad++;
            end
        chk(bad == 0, tag, longint'(mem_m[ba]), longint'(ref_m[ba]));
    endtask

    function automatic string vec_tag(input int i);
        case (i)
            0, 1, 2: return "R1 R2 R3 fill";
            3:       return "R1 R2 fill past edge";
            4:       return "R4 disjoint copy";
            5:       return "R5 overlap down";
            6:       return "R6 overlap up";
            7:       return "R6 same-row shift right";
            8:       return "R6 same-row shift left";
            default: return "R2 fill off screen";
        endcase
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int ex, ey, ew, eh, acc0, dc0, rd0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R13 reset state
        chk(cmd_ready == 1'b1, "R13 cmd_ready", longint'(cmd_ready), 1);
        chk(mem_req == 1'b0 && done == 1'b0 && dmg_valid == 1'b0, "R13 idle outputs",
            longint'({mem_req, done, dmg_valid}), 0);

        // Vector table
        for (int v = 0; v < NVEC; v++) begin
            vec_t t = VECS[v];
            load_mem();
            cfg_bpp = t.bpp;
            win_on = 1'b0;
            if (t.op == 1'b0) begin
                win_lo = int'(t.bpp) * (int'(t.dx) + SCR_W * int'(t.dy));
                win_hi = win_lo + int'(t.bpp) * int'(t.w);
                win_on = 1'b1;
            end
            @(negedge clk);
            rd0 = rd_cnt; dc0 = done_cnt;
            run_cmd(t.op, t.col, t.sx, t.sy, t.dx, t.dy, t.w, t.h);
            win_on = 1'b0;
            if (t.op == 1'b0)
                ref_fill(int'(t.bpp), t.col, int'(t.dx), int'(t.dy), int'(t.w), int'(t.h));
            else
                ref_copy(int'(t.bpp), int'(t.sx), int'(t.sy), int'(t.dx), int'(t.dy),
                         int'(t.w), int'(t.h));
            cmp_mem(vec_tag(v));
            chk(done_cnt - dc0 == 1, "R9 one done per command", longint'(done_cnt - dc0), 1);
            if (t.op == 1'b0)
                chk(bad_rd == 0 && rd_cnt - rd0 == (int'(t.h) - 1) * int'(t.bpp) * int'(t.w),
                    "R3 reads only first row", longint'(rd_cnt - rd0),
                    longint'((int'(t.h) - 1) * int'(t.bpp) * int'(t.w)));
            clamp(int'(t.dx), int'(t.w), SCR_W, ex, ew);
            clamp(int'(t.dy), int'(t.h), SCR_H, ey, eh);
            get_dmg(1'b0);
            chk(got_n == 1 && int'(got_x[0]) == ex && int'(got_w[0]) == ew &&
                int'(got_y[0]) == ey && int'(got_h[0]) == eh,
                "R10 R11 damage rect",
                longint'({got_x[0], got_y[0], got_w[0], got_h[0]}),
                longint'({12'(ex), 12'(ey), 12'(ew), 12'(eh)}));
        end

        // R7 zero width and zero height
        cfg_bpp = 3'd1;
        load_mem();
        acc0 = acc_cnt; dc0 = done_cnt;
        run_cmd(1'b0, 32'h11, 12'd0, 12'd0, 12'd3, 12'd3, 12'd0, 12'd2);
        run_cmd(1'b1, 32'h0,  12'd0, 12'd0, 12'd3, 12'd3, 12'd2, 12'd0);
        chk(acc_cnt == acc0, "R7 no memory access", longint'(acc_cnt - acc0), 0);
        chk(done_cnt - dc0 == 2, "R7 done pulses", longint'(done_cnt - dc0), 2);
        get_dmg(1'b0);
        chk(got_n == 0, "R7 no damage entry", longint'(got_n), 0);

        // R8 command offered while busy is ignored
        load_mem();
        dc0 = done_cnt;
        @(negedge clk);
        cmd_op = 1'b0; cmd_color = 32'hC3; cmd_dx = 12'd0; cmd_dy = 12'd0;
        cmd_w = 12'd16; cmd_h = 12'd4; cmd_valid = 1'b1;
        @(negedge clk);
        cmd_dy = 12'd6; cmd_w = 12'd1; cmd_h = 12'd1; cmd_color = 32'h55;
        begin
            int rdy_seen = 0;
            for (int k = 0; k < 5; k++) begin
                @(negedge clk);
                if (cmd_ready) rdy_seen++;
            end
            chk(rdy_seen == 0, "R8 ready low while busy", longint'(rdy_seen), 0);
        end
        cmd_valid = 1'b0;
        while (!done) @(negedge clk);
        repeat (20) @(negedge clk);
        ref_fill(1, 32'hC3, 0, 0, 16, 4);
        cmp_mem("R8 busy command ignored");
        chk(done_cnt - dc0 == 1, "R8 single completion", longint'(done_cnt - dc0), 1);
        get_dmg(1'b0);

        // R10 order of queued rectangles
        run_cmd(1'b0, 32'h9, 12'd1, 12'd1, 12'd1, 12'd1, 12'd2, 12'd2);
        run_cmd(1'b1, 32'h0, 12'd1, 12'd1, 12'd5, 12'd5, 12'd2, 12'd2);
        get_dmg(1'b0);
        chk(got_n == 2 && got_x[0] == 12'd1 && got_y[0] == 12'd1 &&
            got_x[1] == 12'd5 && got_y[1] == 12'd5,
            "R10 queue order", longint'({got_x[0], got_x[1]}), longint'({12'd1, 12'd5}));

        // R12 invalidate discards the queue
        run_cmd(1'b0, 32'h9, 12'd0, 12'd0, 12'd2, 12'd2, 12'd1, 12'd1);
        run_cmd(1'b0, 32'h9, 12'd0, 12'd0, 12'd3, 12'd3, 12'd1, 12'd1);
        get_dmg(1'b1);
        chk(got_n == 0, "R12 no output on discard", longint'(got_n), 0);
        get_dmg(1'b0);
        chk(got_n == 0, "R12 queue empty afterwards", longint'(got_n), 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule